// File: doc/BRIEF.md
# Capacitive Touch Scanner with Gate-Time Counting

This block senses several capacitive touch elements one after another. An external relaxation oscillator is switched onto the element named by the select output. The block counts its rising edges over a gate window of programmable length, measured in reference-clock ticks. A finger adds capacitance, which slows the oscillator, so a touch shows up as a count that falls below that element's learned baseline.

Each element keeps its own baseline. The first window on an element seeds the baseline. After that, the baseline drifts slowly toward new readings while the element is idle, and it is frozen while the element is touched. After every window the block reports the raw count, the drop below baseline and the element that was measured. It keeps one touch flag per element, and it names the touched element with the biggest drop.

Top module: `touch_scan`

## Requirements
- R1: The oscillator input is resampled by two flip-flops, and a rising edge is detected between the second flop and a third delay flop. Each detected edge adds one to the window count, so an edge at the pin is counted three clock edges after it arrives.
- R2: A window spans `cfg_gate` cycles of `ref_en` (a value of 0 acts as 1). The window closes on the clock where `ref_en` is high and the tick count has reached `cfg_gate`-1. An edge detected in that closing cycle is included in the count. The count stops at 2^CW-1 and does not wrap.
- R3: One clock after a window closes, `res_valid` is high for that cycle. `raw_count` then holds the window count and `res_elem` holds the element that was measured.
- R4: `delta` equals baseline minus count when the count is below the baseline. Otherwise `delta` is 0.
- R5: An element's touch flag is set when its delta is strictly greater than `cfg_thresh`, and it is updated at each of that element's windows. Flags of elements whose index is at or above the active element count read 0.
- R6: `sel` steps through 0 up to the active element count minus 1, then wraps to 0. The active element count is `cfg_elems`, where 0 acts as 1 and values above N act as N. `sel` changes only when a window closes.
- R7: `dominant` is the touched, active element with the largest stored delta. On a tie, the lowest index wins. `dom_valid` is high when any active element is touched; when none is, `dominant` reads 0.
- R8: The first window on an element after reset loads its baseline with the count, and reports a delta of 0 with no touch.
- R9: At each later window of an untouched element, the baseline becomes baseline + floor((count − baseline)/16). While the element is touched, its baseline is held.
- R10: Reset clears `sel` and all result outputs and flags to 0, and marks every baseline as not yet loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_en | input | 1 | Reference tick, high for one clock per tick |
| osc_in | input | 1 | Relaxation oscillator, asynchronous |
| cfg_gate | input | GW | Window length in reference ticks |
| cfg_thresh | input | CW | Touch threshold on delta |
| cfg_elems | input | NW | Number of elements to scan |
| sel | output | IW | Element currently connected to the oscillator |
| res_valid | output | 1 | Pulse marking a finished window |
| res_elem | output | IW | Element of the last result |
| raw_count | output | CW | Edge count of the last window |
| delta | output | CW | Drop below baseline of the last window |
| touch | output | N | Touch flag per element |
| dom_valid | output | 1 | Some active element is touched |
| dominant | output | IW | Touched element with the largest delta |

## Verification
The assertions assume that `ref_en` ticks at least a few clocks apart. They also assume that the oscillator, once it has been through the synchronizer, yields at most one edge per clock, so the count rises by at most one per cycle and windows never close on back-to-back clocks. The bench drives `ref_en` once every four clocks. It toggles `osc_in` only on falling clock edges, with a half period of one or more clocks that depends on the selected element. It changes the configuration only between whole scans. The fastest half period, one clock, drives the narrowed counter into saturation.

// File: rtl/touch_scan.sv
module touch_scan #(
  parameter int N  = 4,
  parameter int CW = 16,
  parameter int GW = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int NW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_en,
  input  logic          osc_in,
  input  logic [GW-1:0] cfg_gate,
  input  logic [CW-1:0] cfg_thresh,
  input  logic [NW-1:0] cfg_elems,
  output logic [IW-1:0] sel,
  output logic          res_valid,
  output logic [IW-1:0] res_elem,
  output logic [CW-1:0] raw_count,
  output logic [CW-1:0] delta,
  output logic [N-1:0]  touch,
  output logic          dom_valid,
  output logic [IW-1:0] dominant
);
  localparam logic [CW-1:0] MAXC = '1;

  logic [2:0]    sy;
  logic          rise;
  logic [GW-1:0] gcnt, last;
  logic          win_end;
  logic [CW-1:0] cnt, meas;
  logic [NW-1:0] nact;
  logic          wrap;

  logic [CW-1:0] base [N];
  logic [CW-1:0] dlt  [N];
  logic [N-1:0]  init, tch;

  logic [CW-1:0]        cur_base, drop, new_base;
  logic signed [CW+1:0] diff, step;
  logic                 hit;

  assign rise    = sy[1] & ~sy[2];
  assign last    = (cfg_gate == '0) ? '0 : cfg_gate - GW'(1);
  assign win_end = ref_en && (gcnt >= last);
  assign meas    = (cnt == MAXC) ? cnt : cnt + CW'(rise);
  assign nact    = (cfg_elems == '0) ? NW'(1) : (cfg_elems > NW'(N)) ? NW'(N) : cfg_elems;
  assign wrap    = (NW'(sel) + NW'(1)) >= nact;

  assign cur_base = base[sel];
  assign drop     = (cur_base > meas) ? cur_base - meas : '0;
  assign hit      = drop > cfg_thresh;
  assign diff     = $signed({2'b00, meas}) - $signed({2'b00, cur_base});
  assign step     = diff >>> 4;
  assign new_base = cur_base + step[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= '0;
      gcnt <= '0;
      cnt  <= '0;
    end else begin
      sy <= {sy[1:0], osc_in};
      if (win_end) begin
        gcnt <= '0;
        cnt  <= '0;
      end else begin
        if (ref_en) gcnt <= gcnt + GW'(1);
        cnt <= meas;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel       <= '0;
      res_valid <= 1'b0;
      res_elem  <= '0;
      raw_count <= '0;
      delta     <= '0;
      init      <= '0;
      tch       <= '0;
      for (int i = 0; i < N; i++) begin
        base[i] <= '0;
        dlt[i]  <= '0;
      end
    end else begin
      res_valid <= win_end;
      if (win_end) begin
        raw_count <= meas;
        res_elem  <= sel;
        sel       <= wrap ? '0 : sel + IW'(1);
        if (!init[sel]) begin
          init[sel] <= 1'b1;
          base[sel] <= meas;
          dlt[sel]  <= '0;
          tch[sel]  <= 1'b0;
          delta     <= '0;
        end else begin
          dlt[sel] <= drop;
          tch[sel] <= hit;
          delta    <= drop;
          if (!hit) base[sel] <= new_base;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) touch[i] = tch[i] && (NW'(i) < nact);
  end

  assign dom_valid = |touch;

  always_comb begin
    logic [CW-1:0] best;
    logic          found;
    best     = '0;
    found    = 1'b0;
    dominant = '0;
    for (int i = 0; i < N; i++) begin
      if (touch[i] && (!found || dlt[i] > best)) begin
        best     = dlt[i];
        found    = 1'b1;
        dominant = IW'(i);
      end
    end
  end

  // R2
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAXC && !win_end) |=> cnt == MAXC);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + CW'(1)));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(sel));

  // R3
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R5
  touch_delta_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && tch[res_elem]) |-> delta != '0);

  // R7
  dom_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dom_valid |-> touch[dominant]);
endmodule

// File: tb/touch_scan_tb.sv
module touch_scan_tb;
  localparam int CLK_P = 10;
  localparam int N = 4, CW = 8, GW = 16, IW = 2, NW = 3;
  localparam int MAXV = 255;

  logic clk = 0, rst_n = 0, ref_en = 0, osc_in = 0;
  logic [GW-1:0] cfg_gate = 64;
  logic [CW-1:0] cfg_thresh = 8;
  logic [NW-1:0] cfg_elems = 4;
  logic [IW-1:0] sel, res_elem, dominant;
  logic res_valid, dom_valid;
  logic [CW-1:0] raw_count, delta;
  logic [N-1:0] touch;

  touch_scan #(.N(N), .CW(CW), .GW(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .osc_in(osc_in),
    .cfg_gate(cfg_gate), .cfg_thresh(cfg_thresh), .cfg_elems(cfg_elems),
    .sel(sel), .res_valid(res_valid), .res_elem(res_elem),
    .raw_count(raw_count), .delta(delta), .touch(touch),
    .dom_valid(dom_valid), .dominant(dominant));

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;

  int s1, s2, s3, g, c;
  int m_sel, m_rv, m_relem, m_raw, m_delta;
  int mbase[N], mdlt[N], minit[N], mtch[N];

  function automatic int act_n();
    int n = int'(cfg_elems);
    if (n == 0) n = 1;
    if (n > N) n = N;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      s1 = 0; s2 = 0; s3 = 0; g = 0; c = 0;
      m_sel = 0; m_rv = 0; m_relem = 0; m_raw = 0; m_delta = 0;
      for (int i = 0; i < N; i++) begin
        mbase[i] = 0; mdlt[i] = 0; minit[i] = 0; mtch[i] = 0;
      end
    end else begin
      int r, lst, meas, d;
      bit wend;
      r = (s2 && !s3) ? 1 : 0;
      lst = (cfg_gate == 0) ? 0 : int'(cfg_gate) - 1;
      wend = ref_en && (g >= lst);
      meas = (c + r > MAXV) ? MAXV : c + r;
      m_rv = wend;
      if (wend) begin
        m_raw = meas;
        m_relem = m_sel;
        if (!minit[m_sel]) begin
          minit[m_sel] = 1; mbase[m_sel] = meas; mdlt[m_sel] = 0;
          mtch[m_sel] = 0; m_delta = 0;
        end else begin
          d = (mbase[m_sel] > meas) ? mbase[m_sel] - meas : 0;
          mdlt[m_sel] = d;
          m_delta = d;
          mtch[m_sel] = (d > int'(cfg_thresh));
          if (!mtch[m_sel]) mbase[m_sel] = mbase[m_sel] + ((meas - mbase[m_sel]) >>> 4);
        end
        m_sel = (m_sel + 1 >= act_n()) ? 0 : m_sel + 1;
        g = 0; c = 0;
      end else begin
        if (ref_en) g = g + 1;
        c = meas;
      end
      s3 = s2; s2 = s1; s1 = osc_in;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int et, bd, bv, fnd;
    et = 0; bd = 0; bv = 0; fnd = 0;
    for (int i = 0; i < N; i++) begin
      if (mtch[i] && i < act_n()) begin
        et |= (1 << i);
        if (!fnd || mdlt[i] > bv) begin bv = mdlt[i]; bd = i; fnd = 1; end
      end
    end
    chk(int'(sel) == m_sel, "R6 sel", int'(sel), m_sel);
    chk(int'(res_valid) == m_rv, "R3 res_valid", int'(res_valid), m_rv);
    chk(int'(res_elem) == m_relem, "R3 res_elem", int'(res_elem), m_relem);
    chk(int'(raw_count) == m_raw, "R1/R2 raw_count", int'(raw_count), m_raw);
    chk(int'(delta) == m_delta, "R4/R8/R9 delta", int'(delta), m_delta);
    chk(int'(touch) == et, "R5 touch", int'(touch), et);
    chk(int'(dom_valid) == fnd, "R7 dom_valid", int'(dom_valid), fnd);
    chk(int'(dominant) == bd, "R7 dominant", int'(dominant), bd);
  endtask

  int hp[N] = '{3, 2, 4, 3};
  int ph = 0, cyc = 0;

  task automatic run(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare_all();
      cyc++;
      ref_en = (cyc % 4 == 0);
      ph++;
      if (ph >= hp[m_sel]) begin osc_in = ~osc_in; ph = 0; end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(sel == 0 && res_valid == 0 && raw_count == 0 && delta == 0, "R10 reset outputs", int'(raw_count), 0);
    chk(touch == 0 && dom_valid == 0 && dominant == 0, "R10 reset flags", int'(touch), 0);
    rst_n = 1;
    // R8 seeding and R9 settling on idle elements
    run(256 * 12);
    chk(touch == 0, "R8 no touch when idle", int'(touch), 0);
    // R5 and R7: two elements touched, element 1 drops furthest
    hp[2] = 6; hp[1] = 3;
    run(256 * 8);
    chk(touch[2] == 1 && touch[1] == 1, "R5 touched flags", int'(touch), 6);
    chk(dominant == 1 && dom_valid == 1, "R7 largest delta wins", int'(dominant), 1);
    // R9 baseline frozen while touched: release gives delta back near zero
    hp[1] = 2;
    run(256 * 8);
    chk(touch[1] == 0, "R9 release clears touch", int'(touch[1]), 0);
    // R6 and R5 masking with two active elements, element 2 still touched
    cfg_elems = 2;
    run(256 * 8);
    chk(touch[2] == 0 && sel < 2, "R5/R6 masked and wrapped", int'(touch), 0);
    hp[2] = 4;
    // R2 saturation with a long window and the fastest oscillator
    cfg_elems = 1; cfg_gate = 200; hp[0] = 1;
    for (int w = 0; w < 3; w++) begin
      run(1);
      while (!res_valid) run(1);
      if (w > 0) chk(int'(raw_count) == MAXV, "R2 saturated count", int'(raw_count), MAXV);
    end
    run(20);
    finish_run();
  end
endmodule